// File: doc/BRIEF.md
# Segmented Downward Stack Pointer

This block generates the memory address for every system stack push and pop. The stack address is 24 bits wide: an 8-bit segment register supplies the upper bits and a 16-bit offset register supplies the lower bits. The stack grows toward lower addresses. A push first lowers the offset and then writes at the lowered address. A pop reads at the current offset and then raises it. All pointer arithmetic stays inside the 16-bit offset and wraps modulo 2^16, so a stack never leaves its 64 KB segment.

Each request carries a word or byte size. Two limit registers watch the offset after each update and raise sticky overflow and underflow flags. Software can load the offset, the segment and both limits, and these loads take precedence over stack traffic in the same cycle. A push and a pop requested together is rejected and recorded in an error flag.

Top module: `stack_addr_unit`

## Requirements
- R1: After reset the offset is 0xFC00, the segment is 0x00, `stackAddr` reads 0x00FC00, and `addrValid`, `ovfFlag`, `udfFlag` and `errFlag` are all 0.
- R2: When no access is granted, `stackAddr` is {segment, offset} and `addrValid` is 0. In a granted push or pop cycle `addrValid` is 1 in that same cycle.
- R3: A granted push (`pushReq`=1, `popReq`=0, no offset or segment load) presents {segment, base − step} on `stackAddr` in the same cycle, and the offset holds that value from the next cycle on. The step is 1 when `byteSize`=1 and 2 when `byteSize`=0 (word).
- R4: A granted pop presents {segment, base} on `stackAddr`, and the offset becomes base + step from the next cycle on.
- R5: For a word access (`byteSize`=0) the base is the offset with bit 0 forced to 0. For a byte access the base is the offset itself. A word access therefore never shows an odd address.
- R6: Offset arithmetic wraps modulo 2^16. A push or pop never changes the segment.
- R7: When `offWrEn` or `segWrEn` is 1, a push or pop requested in that cycle is dropped (`addrValid`=0). The loaded register takes the write data at the next edge.
- R8: `pushReq` and `popReq` both at 1 without a load leaves the offset unchanged, keeps `addrValid` at 0 and sets a sticky `errFlag`. A write to the offset clears `errFlag`.
- R9: When a push leaves the offset below the overflow limit (unsigned compare), `ovfFlag` is set and stays set. Writing the overflow limit clears it, and that clear wins over a set in the same cycle.
- R10: When a pop leaves the offset above the underflow limit (unsigned compare), `udfFlag` is set and stays set. Writing the underflow limit clears it, and that clear wins over a set in the same cycle.
- R11: The limits reset to 0x0000 (overflow) and 0xFFFF (underflow). With these values neither flag ever sets, including across a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pushReq | input | 1 | Push request strobe |
| popReq | input | 1 | Pop request strobe |
| byteSize | input | 1 | 1 = byte access, 0 = word access |
| offWrEn | input | 1 | Load the offset register |
| offWrData | input | 16 | New offset value |
| segWrEn | input | 1 | Load the segment register |
| segWrData | input | 8 | New segment value |
| ovfLimWrEn | input | 1 | Load the overflow limit and clear `ovfFlag` |
| ovfLimWrData | input | 16 | New overflow limit |
| udfLimWrEn | input | 1 | Load the underflow limit and clear `udfFlag` |
| udfLimWrData | input | 16 | New underflow limit |
| stackAddr | output | 24 | Stack memory address |
| addrValid | output | 1 | A granted push or pop uses `stackAddr` this cycle |
| ovfFlag | output | 1 | Sticky overflow flag |
| udfFlag | output | 1 | Sticky underflow flag |
| errFlag | output | 1 | Sticky illegal-request flag |

## Verification
Random sequences mix word and byte pushes and pops with odd and even offsets. These show whether the decrement comes before the access on a push and after it on a pop, and whether bit 0 is masked only for words. Directed runs load offsets of 0x0000 and 0xFFFE under a non-zero segment, which shows a wrap that stays in the offset apart from one that carries into the segment. Further runs place the offset exactly at a limit and one step past it, which shows a strict compare apart from an inclusive one. Simultaneous push, pop and load patterns show the load priority and the rejection of the illegal pair.

// File: rtl/stack_addr_pkg.sv
package stack_addr_pkg;
  parameter int OFF_W = 16;
  parameter int SEG_W = 8;
  parameter logic [OFF_W-1:0] OFF_RST = 16'hFC00;
  parameter logic [SEG_W-1:0] SEG_RST = '0;
  localparam int ADDR_W = OFF_W + SEG_W;

  typedef struct packed {
    logic doPush;
    logic doPop;
    logic byteSz;
    logic loadOff;
    logic loadSeg;
    logic loadOvf;
    logic loadUdf;
    logic illegal;
  } stackStrobes_t;
endpackage

// File: rtl/stack_addr_ctrl.sv
module stack_addr_ctrl
  import stack_addr_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushReq,
  input  logic          popReq,
  input  logic          byteSize,
  input  logic          offWrEn,
  input  logic          segWrEn,
  input  logic          ovfLimWrEn,
  input  logic          udfLimWrEn,
  output stackStrobes_t strobes
);
  logic anyLoad;

  always_comb begin
    anyLoad         = offWrEn | segWrEn;
    strobes.doPush  = pushReq & ~popReq & ~anyLoad;
    strobes.doPop   = popReq & ~pushReq & ~anyLoad;
    strobes.illegal = pushReq & popReq & ~anyLoad;
    strobes.byteSz  = byteSize;
    strobes.loadOff = offWrEn;
    strobes.loadSeg = segWrEn;
    strobes.loadOvf = ovfLimWrEn;
    strobes.loadUdf = udfLimWrEn;
  end

  // R7: a load cycle never grants a stack access
  p_load_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (offWrEn || segWrEn) |-> !(strobes.doPush || strobes.doPop));
endmodule

// File: rtl/stack_addr_dp.sv
module stack_addr_dp
  import stack_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  stackStrobes_t     strobes,
  input  logic [OFF_W-1:0]  offWrData,
  input  logic [SEG_W-1:0]  segWrData,
  input  logic [OFF_W-1:0]  ovfLimWrData,
  input  logic [OFF_W-1:0]  udfLimWrData,
  output logic [ADDR_W-1:0] stackAddr,
  output logic              addrValid,
  output logic              ovfFlag,
  output logic              udfFlag,
  output logic              errFlag
);
  logic [OFF_W-1:0] offReg, ovfLim, udfLim;
  logic [SEG_W-1:0] segReg;
  logic [OFF_W-1:0] baseOff, stepVal, pushOff, popOff, addrOff, nextOff;
  logic             ovfHit, udfHit;

  always_comb begin
    baseOff = strobes.byteSz ? offReg : {offReg[OFF_W-1:1], 1'b0};
    stepVal = strobes.byteSz ? OFF_W'(1) : OFF_W'(2);
    pushOff = baseOff - stepVal;
    popOff  = baseOff + stepVal;
    if (strobes.doPush)     addrOff = pushOff;
    else if (strobes.doPop) addrOff = baseOff;
    else                    addrOff = offReg;
    if (strobes.loadOff)    nextOff = offWrData;
    else if (strobes.doPush) nextOff = pushOff;
    else if (strobes.doPop)  nextOff = popOff;
    else                     nextOff = offReg;
    ovfHit    = strobes.doPush && (pushOff < ovfLim);
    udfHit    = strobes.doPop && (popOff > udfLim);
    stackAddr = {segReg, addrOff};
    addrValid = strobes.doPush | strobes.doPop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offReg  <= OFF_RST;
      segReg  <= SEG_RST;
      ovfLim  <= '0;
      udfLim  <= '1;
      ovfFlag <= 1'b0;
      udfFlag <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      offReg <= nextOff;
      if (strobes.loadSeg) segReg <= segWrData;
      if (strobes.loadOvf) ovfLim <= ovfLimWrData;
      if (strobes.loadUdf) udfLim <= udfLimWrData;
      ovfFlag <= strobes.loadOvf ? 1'b0 : (ovfFlag | ovfHit);
      udfFlag <= strobes.loadUdf ? 1'b0 : (udfFlag | udfHit);
      errFlag <= strobes.loadOff ? 1'b0 : (errFlag | strobes.illegal);
    end
  end

  // R3: the address shown by a push becomes the stored offset
  p_push_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doPush |=> (offReg == $past(stackAddr[OFF_W-1:0])));
  // R4: a pop moves the offset one step above the address it used
  p_pop_commit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doPop && !strobes.byteSz) |=>
      (offReg == OFF_W'($past(stackAddr[OFF_W-1:0]) + OFF_W'(2))));
  // R5: word accesses are even
  p_word_even_r5: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !strobes.byteSz) |-> !stackAddr[0]);
  // R6: the segment only moves on a load
  p_seg_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadSeg |=> $stable(segReg));
  // R8: an illegal pair leaves the offset and raises the error flag
  p_illegal_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.illegal |=> ($stable(offReg) && errFlag));
  // R9: overflow flag is sticky until its limit is written
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !strobes.loadOvf) |=> ovfFlag);
  // R10: underflow flag is sticky until its limit is written
  p_udf_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (udfFlag && !strobes.loadUdf) |=> udfFlag);
endmodule

// File: rtl/stack_addr_unit.sv
module stack_addr_unit
  import stack_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              byteSize,
  input  logic              offWrEn,
  input  logic [OFF_W-1:0]  offWrData,
  input  logic              segWrEn,
  input  logic [SEG_W-1:0]  segWrData,
  input  logic              ovfLimWrEn,
  input  logic [OFF_W-1:0]  ovfLimWrData,
  input  logic              udfLimWrEn,
  input  logic [OFF_W-1:0]  udfLimWrData,
  output logic [ADDR_W-1:0] stackAddr,
  output logic              addrValid,
  output logic              ovfFlag,
  output logic              udfFlag,
  output logic              errFlag
);
  stackStrobes_t strobes;

  stack_addr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .byteSize(byteSize), .offWrEn(offWrEn), .segWrEn(segWrEn),
    .ovfLimWrEn(ovfLimWrEn), .udfLimWrEn(udfLimWrEn), .strobes(strobes)
  );

  stack_addr_dp i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .offWrData(offWrData),
    .segWrData(segWrData), .ovfLimWrData(ovfLimWrData),
    .udfLimWrData(udfLimWrData), .stackAddr(stackAddr),
    .addrValid(addrValid), .ovfFlag(ovfFlag), .udfFlag(udfFlag),
    .errFlag(errFlag)
  );
endmodule

// File: tb/test_stack_addr_unit.sv
`timescale 1ns/1ps
module test_stack_addr_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushReq = 0, popReq = 0, byteSize = 0;
  logic offWrEn = 0, segWrEn = 0, ovfLimWrEn = 0, udfLimWrEn = 0;
  logic [15:0] offWrData = 0, ovfLimWrData = 0, udfLimWrData = 0;
  logic [7:0]  segWrData = 0;
  logic [23:0] stackAddr;
  logic addrValid, ovfFlag, udfFlag, errFlag;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [15:0] mOff, mOvfLim, mUdfLim;
  logic [7:0]  mSeg;
  logic mOvf, mUdf, mErr;

  always #2.5 clk = ~clk;

  stack_addr_unit i_stack_addr_unit (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .byteSize(byteSize), .offWrEn(offWrEn), .offWrData(offWrData),
    .segWrEn(segWrEn), .segWrData(segWrData), .ovfLimWrEn(ovfLimWrEn),
    .ovfLimWrData(ovfLimWrData), .udfLimWrEn(udfLimWrEn),
    .udfLimWrData(udfLimWrData), .stackAddr(stackAddr),
    .addrValid(addrValid), .ovfFlag(ovfFlag), .udfFlag(udfFlag),
    .errFlag(errFlag)
  );

  function automatic logic [15:0] baseOf(logic [15:0] off, logic isByte);
    return isByte ? off : {off[15:1], 1'b0};
  endfunction

  function automatic logic [15:0] stepOf(logic isByte);
    return isByte ? 16'd1 : 16'd2;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic push, logic pop, logic isByte,
                      logic oW, logic [15:0] oV, logic sW, logic [7:0] sV,
                      logic vW, logic [15:0] vV, logic uW, logic [15:0] uV);
    logic anyWr, isPush, isPop, illegal;
    logic [15:0] bse, stp, eOff, nOff;
    @(negedge clk);
    pushReq = push; popReq = pop; byteSize = isByte;
    offWrEn = oW; offWrData = oV; segWrEn = sW; segWrData = sV;
    ovfLimWrEn = vW; ovfLimWrData = vV; udfLimWrEn = uW; udfLimWrData = uV;
    #1;
    anyWr   = oW | sW;
    isPush  = push & ~pop & ~anyWr;
    isPop   = pop & ~push & ~anyWr;
    illegal = push & pop & ~anyWr;
    bse = baseOf(mOff, isByte);
    stp = stepOf(isByte);
    eOff = isPush ? bse - stp : (isPop ? bse : mOff);
    chk(tag, "stackAddr", 32'(stackAddr), 32'({mSeg, eOff}));
    chk(tag, "addrValid", 32'(addrValid), 32'(isPush | isPop));
    chk(tag, "flags", 32'({ovfFlag, udfFlag, errFlag}), 32'({mOvf, mUdf, mErr}));
    @(posedge clk);
    nOff = oW ? oV : (isPush ? bse - stp : (isPop ? bse + stp : mOff));
    mOvf = vW ? 1'b0 : (mOvf | (isPush && ((bse - stp) < mOvfLim)));
    mUdf = uW ? 1'b0 : (mUdf | (isPop && ((bse + stp) > mUdfLim)));
    mErr = oW ? 1'b0 : (mErr | illegal);
    mOff = nOff;
    if (sW) mSeg = sV;
    if (vW) mOvfLim = vV;
    if (uW) mUdfLim = uV;
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 16'h0, 0, 8'h0, 0, 16'h0, 0, 16'h0);
  endtask

  task automatic setOff(string tag, logic [15:0] v);
    step(tag, 0, 0, 0, 1, v, 0, 8'h0, 0, 16'h0, 0, 16'h0);
  endtask

  task automatic push(string tag, logic isByte);
    step(tag, 1, 0, isByte, 0, 16'h0, 0, 8'h0, 0, 16'h0, 0, 16'h0);
  endtask

  task automatic pop(string tag, logic isByte);
    step(tag, 0, 1, isByte, 0, 16'h0, 0, 8'h0, 0, 16'h0, 0, 16'h0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    mOff = 16'hFC00; mSeg = 8'h00; mOvfLim = 16'h0000; mUdfLim = 16'hFFFF;
    mOvf = 0; mUdf = 0; mErr = 0;
    r = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state
    idle("R1");
    // R2: idle shows the register value, push shows a granted access
    push("R2", 0);
    idle("R2");
    // R3 / R4: word and byte steps
    push("R3", 0); push("R3", 1); idle("R3");
    pop("R4", 1); pop("R4", 0); idle("R4");
    // R5: odd offset with word and byte accesses
    setOff("R5", 16'h1235);
    push("R5", 0); idle("R5");
    setOff("R5", 16'h1235);
    pop("R5", 0); idle("R5");
    setOff("R5", 16'h1235);
    push("R5", 1); idle("R5");
    // R6: wrap under a non-zero segment
    step("R6", 0, 0, 0, 0, 16'h0, 1, 8'h5A, 0, 16'h0, 0, 16'h0);
    setOff("R6", 16'h0000);
    push("R6", 0); idle("R6");
    pop("R6", 0); idle("R6");
    setOff("R6", 16'hFFFF);
    pop("R6", 1); idle("R6");
    // R11: default limits never flag across wraps
    setOff("R11", 16'h0001);
    push("R11", 1); push("R11", 1); idle("R11");
    setOff("R11", 16'hFFFE);
    pop("R11", 1); pop("R11", 1); idle("R11");
    chk("R11", "no flags", 32'({ovfFlag, udfFlag}), 32'h0);
    // R7: load priority over push and pop
    step("R7", 1, 0, 0, 1, 16'h4000, 0, 8'h0, 0, 16'h0, 0, 16'h0);
    idle("R7");
    step("R7", 0, 1, 0, 0, 16'h0, 1, 8'h33, 0, 16'h0, 0, 16'h0);
    idle("R7");
    step("R7", 1, 1, 1, 1, 16'h4100, 0, 8'h0, 0, 16'h0, 0, 16'h0);
    idle("R7");
    // R8: illegal pair, sticky error, cleared by offset write
    step("R8", 1, 1, 0, 0, 16'h0, 0, 8'h0, 0, 16'h0, 0, 16'h0);
    idle("R8");
    push("R8", 0); idle("R8");
    setOff("R8", 16'h4100);
    idle("R8");
    // R9: overflow limit, strict compare, clear on limit write
    step("R9", 0, 0, 0, 1, 16'h1002, 0, 8'h0, 1, 16'h1000, 0, 16'h0);
    push("R9", 0); idle("R9");
    push("R9", 0); idle("R9");
    push("R9", 1); idle("R9");
    step("R9", 1, 0, 0, 0, 16'h0, 0, 8'h0, 1, 16'h0000, 0, 16'h0);
    idle("R9");
    // R10: underflow limit, strict compare, clear on limit write
    step("R10", 0, 0, 0, 1, 16'h1FFE, 0, 8'h0, 0, 16'h0, 1, 16'h2000);
    pop("R10", 0); idle("R10");
    pop("R10", 0); idle("R10");
    step("R10", 0, 1, 0, 0, 16'h0, 0, 8'h0, 0, 16'h0, 1, 16'hFFFF);
    idle("R10");

    // R2: constrained random mix
    for (int i = 0; i < 400; i++) begin
      r = $urandom;
      case (r[3:0])
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: push("R3", r[4]);
        4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11: pop("R4", r[4]);
        4'd12: step("R8", 1, 1, r[4], 0, 16'h0, 0, 8'h0, 0, 16'h0, 0, 16'h0);
        4'd13: step("R7", r[5], r[6], r[4], 1, 16'(r >> 8), 0, 8'h0, 0, 16'h0, 0, 16'h0);
        4'd14: step("R6", r[5], 0, r[4], 0, 16'h0, 1, 8'(r >> 16), 0, 16'h0, 0, 16'h0);
        default: step("R2", r[5], ~r[5], r[4], 0, 16'h0, 0, 8'h0,
                      r[6], 16'(r >> 8), r[7], 16'(r >> 12));
      endcase
    end
    idle("R2");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule